// File: doc/BRIEF.md
# Packet Store-Then-Load Memory Sequencer

This block takes one packet at a time. A packet can carry a store issued from slot 1 and a load, and the block runs them on a single-ported synchronous memory in the order the architecture requires. The load may sit in slot 0 or in another slot, and it may be predicated.

When the load is in slot 0 and the packet also holds a store, the block first probes the load address against an external fault checker. If the probe is clean, the store is written and the load then reads. Overlapping bytes therefore come back with the value just written. A faulting probe ends the packet with no write at all. When the load is in any other slot, the two operations behave as if they ran in parallel: the load reads first and sees the old bytes, and the store follows.

Accesses are 1, 2, 4 or 8 bytes, naturally aligned, and stored little-endian inside a memory word. Narrow loads are zero-extended or sign-extended. A done pulse ends every accepted packet and carries either the load result or a fault flag.

Top module: `pkt_mem_sequencer`

## Requirements
- R1: When a packet holds a store and an active load in slot 0, the block probes the load address, then writes, then reads. The done pulse appears after the fourth rising edge that follows the accepting edge.
- R2: In the slot-0 ordering, every load byte whose address the store covers returns the newly stored byte.
- R3: If the probe reports a fault, the packet makes no memory access. Done and fault are raised after the first edge following acceptance, and ld_data_valid stays low.
- R4: A store whose load is absent, or whose load predicate is false, is written without any probe. Done follows one edge after acceptance, with ld_data_valid low.
- R5: A load with no store is issued as one read with no probe. Done and ld_data_valid follow two edges after acceptance.
- R6: When the load is not in slot 0 and a store is present, the load reads first and returns the pre-store bytes, and the store is written afterwards. Done follows three edges after acceptance.
- R7: The size code selects the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. For 1, 2 and 4 bytes, ld_signed set gives sign extension and ld_signed clear gives zero extension. An 8-byte load is returned unchanged whatever ld_signed is.
- R8: Byte order is little-endian. The byte at address A is data bits 7:0, and the byte at A+1 is bits 15:8.
- R9: A memory write drives mem_addr equal to the byte address shifted right by 3. mem_be bit i is set exactly for lanes i from addr[2:0] to addr[2:0] plus the size in bytes, minus 1. A read drives mem_be all ones.
- R10: While busy is high, pkt_valid and the packet inputs are ignored.
- R11: Under reset, busy, done, mem_en and probe_en are low.
- R12: A packet that has no store and no active load raises done after the accepting edge itself and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Packet present; taken when busy is low |
| st_valid | input | 1 | Packet holds a slot 1 store |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| st_data | input | DATA_W | Store data, right-aligned |
| ld_valid | input | 1 | Packet holds a load |
| ld_in_slot0 | input | 1 | Load sits in slot 0 |
| ld_pred | input | 1 | Load predicate (1 = execute) |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_signed | input | 1 | Sign-extend the narrow load |
| busy | output | 1 | Packet in progress |
| probe_en | output | 1 | Fault probe request |
| probe_addr | output | ADDR_W | Address being probed |
| probe_size | output | 2 | Size being probed |
| probe_fault | input | 1 | Checker result, same cycle |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W-3 | Memory word index |
| mem_be | output | DATA_W/8 | Byte-lane enables |
| mem_wdata | output | DATA_W | Lane-aligned write data |
| mem_rdata | input | DATA_W | Read word, valid one cycle after the read |
| done | output | 1 | One-cycle packet completion pulse |
| fault | output | 1 | Probe fault, valid with done |
| ld_data_valid | output | 1 | ld_data holds a result, valid with done |
| ld_data | output | DATA_W | Extended load result |

## Verification
Each packet shape has a fixed latency, counted in rising edges after the accepting one. An empty packet completes at the accepting edge, a lone store or a faulting probe after one edge, a lone load after two, a load-first pair after three, and a probed store-then-load pair after four. The bench works out that latency from the packet, independently of the RTL. It drives inputs and samples outputs on falling edges, and on every falling edge it requires done to match the expected edge exactly. At that same cycle it compares fault, ld_data_valid and ld_data with a byte-level reference memory that is updated in the architectural order. During the packet it counts probes, reads and writes, and checks the lane enables and word index of every write.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_PROBE = 3'd1,
        SEQ_STORE = 3'd2,
        SEQ_LOAD  = 3'd3,
        SEQ_WAIT  = 3'd4
    } seq_state_e;

    // Number of bytes for a size code (0:1, 1:2, 2:4, 3:8 ...)
    function automatic int unsigned size_bytes(input int unsigned code);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/st_lane_align.sv
module st_lane_align #(
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int SZ_W  = $clog2(OFF_W + 1)
) (
    input  logic [OFF_W-1:0]  lane_off,
    input  logic [SZ_W-1:0]   size,
    input  logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    logic [OFF_W+1:0] first_lane;
    logic [OFF_W+1:0] end_lane;

    always_comb begin
        first_lane = {2'b00, lane_off};
        end_lane   = first_lane + ((OFF_W + 2)'(1) << size);
        wdata      = data << {lane_off, 3'b000};
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W+1:0] LANE_IDX = (OFF_W + 2)'(i);
        assign be[i] = (LANE_IDX >= first_lane) && (LANE_IDX < end_lane);
    end

endmodule

// File: rtl/ld_lane_extract.sv
module ld_lane_extract #(
    parameter int DATA_W = 64,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int SZ_W  = $clog2(OFF_W + 1),
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFF_W-1:0]  lane_off,
    input  logic [SZ_W-1:0]   size,
    input  logic              sext,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] shifted;
    logic [OFF_W+1:0]  keep_lanes;
    logic [BIT_W-1:0]  msb_idx;
    logic              fill;

    always_comb begin
        shifted    = rdata >> {lane_off, 3'b000};
        keep_lanes = (OFF_W + 2)'(1) << size;
        msb_idx    = BIT_W'((32'd8 << size) - 32'd1);
        // The full-width load is always unsigned
        fill       = sext && (32'(size) != OFF_W) && shifted[msb_idx];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W+1:0] LANE_IDX = (OFF_W + 2)'(i);
        assign result[i*8 +: 8] = (LANE_IDX < keep_lanes) ? shifted[i*8 +: 8] : {8{fill}};
    end

endmodule

// File: rtl/pkt_mem_sequencer.sv
module pkt_mem_sequencer
    import pkt_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 64,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int SZ_W   = $clog2(OFF_W + 1),
    localparam int WORD_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_valid,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SZ_W-1:0]   st_size,
    input  logic [DATA_W-1:0] st_data,
    input  logic              ld_valid,
    input  logic              ld_in_slot0,
    input  logic              ld_pred,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SZ_W-1:0]   ld_size,
    input  logic              ld_signed,
    output logic              busy,
    output logic              probe_en,
    output logic [ADDR_W-1:0] probe_addr,
    output logic [SZ_W-1:0]   probe_size,
    input  logic              probe_fault,
    output logic              mem_en,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic              ld_data_valid,
    output logic [DATA_W-1:0] ld_data
);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] st_addr;
        logic [SZ_W-1:0]   st_size;
        logic [DATA_W-1:0] st_data;
        logic [ADDR_W-1:0] ld_addr;
        logic [SZ_W-1:0]   ld_size;
        logic              ld_sext;
        logic              ld_go;     // load will execute
        logic              st_go;     // store present
        logic              ld_early;  // load runs before the store
        logic              st_done;
        logic              done;
        logic              fault;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [LANES-1:0]  st_be;
    logic [DATA_W-1:0] st_wdata;
    logic [DATA_W-1:0] ld_word;

    st_lane_align #(.DATA_W(DATA_W)) u_st_align (
        .lane_off (r_q.st_addr[OFF_W-1:0]),
        .size     (r_q.st_size),
        .data     (r_q.st_data),
        .be       (st_be),
        .wdata    (st_wdata)
    );

    ld_lane_extract #(.DATA_W(DATA_W)) u_ld_extract (
        .rdata    (mem_rdata),
        .lane_off (r_q.ld_addr[OFF_W-1:0]),
        .size     (r_q.ld_size),
        .sext     (r_q.ld_sext),
        .result   (ld_word)
    );

    // Next-state logic
    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.fault    = 1'b0;
        r_d.rd_valid = 1'b0;

        unique case (r_q.state)
            SEQ_IDLE: begin
                if (pkt_valid) begin
                    r_d.st_addr  = st_addr;
                    r_d.st_size  = st_size;
                    r_d.st_data  = st_data;
                    r_d.ld_addr  = ld_addr;
                    r_d.ld_size  = ld_size;
                    r_d.ld_sext  = ld_signed;
                    r_d.ld_go    = ld_valid && ld_pred;
                    r_d.st_go    = st_valid;
                    r_d.ld_early = !ld_in_slot0;
                    r_d.st_done  = 1'b0;
                    if (ld_valid && ld_pred && st_valid && ld_in_slot0) begin
                        r_d.state = SEQ_PROBE;
                    end else if (ld_valid && ld_pred) begin
                        r_d.state = SEQ_LOAD;
                    end else if (st_valid) begin
                        r_d.state = SEQ_STORE;
                    end else begin
                        r_d.done  = 1'b1;
                    end
                end
            end
            SEQ_PROBE: begin
                if (probe_fault) begin
                    r_d.done  = 1'b1;
                    r_d.fault = 1'b1;
                    r_d.state = SEQ_IDLE;
                end else begin
                    r_d.state = SEQ_STORE;
                end
            end
            SEQ_STORE: begin
                r_d.st_done = 1'b1;
                if (r_q.ld_go && !r_q.ld_early) begin
                    r_d.state = SEQ_LOAD;
                end else begin
                    r_d.done     = 1'b1;
                    r_d.rd_valid = r_q.ld_go;
                    r_d.state    = SEQ_IDLE;
                end
            end
            SEQ_LOAD: begin
                r_d.state = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                r_d.rd_data = ld_word;
                if (r_q.st_go && !r_q.st_done) begin
                    r_d.state = SEQ_STORE;
                end else begin
                    r_d.done     = 1'b1;
                    r_d.rd_valid = 1'b1;
                    r_d.state    = SEQ_IDLE;
                end
            end
            default: begin
                r_d.state = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Outputs
    always_comb begin
        busy          = (r_q.state != SEQ_IDLE);
        probe_en      = (r_q.state == SEQ_PROBE);
        probe_addr    = r_q.ld_addr;
        probe_size    = r_q.ld_size;
        mem_en        = (r_q.state == SEQ_STORE) || (r_q.state == SEQ_LOAD);
        mem_we        = (r_q.state == SEQ_STORE);
        mem_addr      = mem_we ? r_q.st_addr[ADDR_W-1:OFF_W] : r_q.ld_addr[ADDR_W-1:OFF_W];
        mem_be        = mem_we ? st_be : '1;
        mem_wdata     = st_wdata;
        done          = r_q.done;
        fault         = r_q.fault;
        ld_data_valid = r_q.rd_valid;
        ld_data       = r_q.rd_data;
    end

    // Checks
    assert_store_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && r_q.st_go && !r_q.ld_early) |-> r_q.st_done);

    assert_fault_blocks_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_en && probe_fault) |=> (!mem_en && done && fault && !ld_data_valid));

    assert_lone_store_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !r_q.ld_go) |=> (done && !ld_data_valid));

    assert_read_no_probe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we && !r_q.st_go) |-> $past(!probe_en));

    assert_lane_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ($countones(mem_be) == (32'd1 << r_q.st_size)));

    assert_busy_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pkt_valid) |=> ($stable(r_q.ld_addr) && $stable(r_q.st_addr) && $stable(r_q.st_data)));

    assert_fault_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && !ld_data_valid));

endmodule

// File: tb/sim_pkt_mem_sequencer.sv
module sim_pkt_mem_sequencer;
    localparam int AW = 10;
    localparam int DW = 64;
    localparam int NB = 8;
    localparam int WORDS = (1 << AW) / NB;
    localparam int FAULT_BASE = 'h300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 0, st_valid = 0, ld_valid = 0, ld_in_slot0 = 0, ld_pred = 0, ld_signed = 0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [1:0] st_size = '0, ld_size = '0;
    logic [DW-1:0] st_data = '0;
    logic busy, probe_en, probe_fault, mem_en, mem_we, done, fault, ld_data_valid;
    logic [AW-1:0] probe_addr;
    logic [1:0] probe_size;
    logic [AW-4:0] mem_addr;
    logic [NB-1:0] mem_be;
    logic [DW-1:0] mem_wdata, ld_data;
    logic [DW-1:0] mem_rdata = '0;

    logic [DW-1:0] bmem [0:WORDS-1];
    logic [7:0] ref_b [0:(1<<AW)-1];

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign probe_fault = probe_en && (int'(probe_addr) >= FAULT_BASE);

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < NB; b++)
                    if (mem_be[b]) bmem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= bmem[mem_addr];
            end
        end
    end

    pkt_mem_sequencer #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
        .ld_valid(ld_valid), .ld_in_slot0(ld_in_slot0), .ld_pred(ld_pred),
        .ld_addr(ld_addr), .ld_size(ld_size), .ld_signed(ld_signed),
        .busy(busy), .probe_en(probe_en), .probe_addr(probe_addr), .probe_size(probe_size),
        .probe_fault(probe_fault), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .ld_data_valid(ld_data_valid), .ld_data(ld_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_load(input int a, input int sz, input bit sg);
        int n = 1 << sz;
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) r[i*8 +: 8] = ref_b[a + i];
        if (sg && sz < 3 && r[n*8-1])
            for (int i = n*8; i < 64; i++) r[i] = 1'b1;
        return r;
    endfunction

    task automatic ref_store(input int a, input int sz, input logic [63:0] d);
        for (int i = 0; i < (1 << sz); i++) ref_b[a + i] = d[i*8 +: 8];
    endtask

    task automatic run_pkt(input bit sv, input int sa, input int ssz, input logic [63:0] sd,
                           input bit lv, input bit l0, input bit lp, input int la, input int lsz,
                           input bit lsg, input bit poke, input string tag);
        bit lact = lv && lp;
        bit first0 = lact && sv && l0;
        bit flt = first0 && (la >= FAULT_BASE);
        int exp_k;
        int probes = 0, writes = 0, reads = 0;
        bit exp_rd = lact && !flt;
        logic [63:0] exp_data = '0;
        logic [7:0] ebe = 8'(((1 << (1 << ssz)) - 1) << (sa % NB));
        bit mem_ok = 1'b1;

        if (first0) exp_k = flt ? 1 : 4;
        else if (lact && sv) exp_k = 3;
        else if (lact) exp_k = 2;
        else if (sv) exp_k = 1;
        else exp_k = 0;

        if (!flt) begin
            if (first0) begin
                ref_store(sa, ssz, sd);
                exp_data = ref_load(la, lsz, lsg);
            end else if (lact) begin
                exp_data = ref_load(la, lsz, lsg);
                if (sv) ref_store(sa, ssz, sd);
            end else if (sv) begin
                ref_store(sa, ssz, sd);
            end
        end

        @(negedge clk);
        pkt_valid = 1; st_valid = sv; st_addr = AW'(sa); st_size = 2'(ssz); st_data = sd;
        ld_valid = lv; ld_in_slot0 = l0; ld_pred = lp; ld_addr = AW'(la);
        ld_size = 2'(lsz); ld_signed = lsg;
        @(posedge clk);
        for (int k = 0; k <= exp_k + 1; k++) begin
            @(negedge clk);
            if (mem_en && mem_we) begin
                writes++;
                chk(mem_be == ebe, {tag, " R9 lane enables"}, 64'(mem_be), 64'(ebe));
                chk(int'(mem_addr) == sa / NB, {tag, " R9 word index"}, 64'(mem_addr), 64'(sa / NB));
            end
            if (mem_en && !mem_we) reads++;
            if (probe_en) probes++;
            chk(done == (k == exp_k), {tag, " done timing"}, 64'(done), 64'(k == exp_k));
            if (k == exp_k) begin
                chk(fault == flt, {tag, " R3 fault flag"}, 64'(fault), 64'(flt));
                chk(ld_data_valid == exp_rd, {tag, " data valid"}, 64'(ld_data_valid), 64'(exp_rd));
                if (exp_rd) chk(ld_data == exp_data, {tag, " load data"}, ld_data, exp_data);
            end
            pkt_valid = 0;
            if (poke && k == 1) begin
                pkt_valid = 1; st_valid = 1; st_addr = AW'(sa ^ 8); st_data = ~sd;
                ld_addr = AW'(la ^ 16);
            end
        end
        pkt_valid = 0;
        chk(probes == (first0 ? 1 : 0), {tag, " probe count"}, 64'(probes), 64'(first0));
        chk(writes == ((sv && !flt) ? 1 : 0), {tag, " write count"}, 64'(writes), 64'(sv && !flt));
        chk(reads == (exp_rd ? 1 : 0), {tag, " read count"}, 64'(reads), 64'(exp_rd));
        for (int a = 0; a < (1 << AW); a++)
            if (bmem[a / NB][(a % NB)*8 +: 8] !== ref_b[a]) mem_ok = 1'b0;
        chk(mem_ok, {tag, " memory image"}, 64'(mem_ok), 64'(1));
    endtask

    initial begin
        for (int a = 0; a < (1 << AW); a++) begin
            ref_b[a] = 8'((a * 37 + 11) & 255);
            bmem[a / NB][(a % NB)*8 +: 8] = 8'((a * 37 + 11) & 255);
        end
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_en && !probe_en, "R11 reset outputs",
            64'({busy, done, mem_en, probe_en}), 64'(0));
        rst_n = 1;

        // R5 R7 R8: lone loads of every width and both extensions
        run_pkt(0, 0, 0, 0, 1, 1, 1, 'h05, 0, 1, 0, "R5 R7 1B signed");
        run_pkt(0, 0, 0, 0, 1, 1, 1, 'h05, 0, 0, 0, "R5 R7 1B unsigned");
        run_pkt(0, 0, 0, 0, 1, 0, 1, 'h06, 1, 1, 0, "R5 R7 2B signed");
        run_pkt(0, 0, 0, 0, 1, 1, 1, 'h08, 2, 1, 0, "R7 4B signed");
        run_pkt(0, 0, 0, 0, 1, 1, 1, 'h0C, 2, 0, 0, "R7 4B unsigned");
        run_pkt(0, 0, 0, 0, 1, 1, 1, 'h10, 3, 1, 0, "R7 8B ignores sign");
        // R4 R8: lone store then narrow loads to see byte placement
        run_pkt(1, 'h40, 3, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0, 0, 0, 0, "R4 R8 8B store");
        run_pkt(0, 0, 0, 0, 1, 1, 1, 'h40, 0, 0, 0, "R8 low byte");
        run_pkt(0, 0, 0, 0, 1, 1, 1, 'h46, 1, 0, 0, "R8 high half");
        // R1 R2: slot-0 ordering with overlap
        run_pkt(1, 'h80, 2, 64'hA5B6C7D8, 1, 1, 1, 'h82, 1, 1, 0, "R1 R2 overlap half");
        run_pkt(1, 'h91, 0, 64'h7E, 1, 1, 1, 'h90, 2, 0, 0, "R1 R2 partial overlap");
        run_pkt(1, 'hA0, 1, 64'hBEEF, 1, 1, 1, 'hB0, 3, 0, 0, "R1 disjoint");
        // R10: extra packet offered while busy
        run_pkt(1, 'hC0, 3, 64'h1122_3344_5566_7788, 1, 1, 1, 'hC4, 2, 1, 1, "R10 busy ignore");
        // R3: probe fault leaves memory alone
        run_pkt(1, 'hD0, 2, 64'hDEAD_BEEF, 1, 1, 1, 'h310, 2, 0, 0, "R3 fault");
        run_pkt(0, 0, 0, 0, 1, 1, 1, 'hD0, 2, 0, 0, "R3 old bytes kept");
        // R4: predicate false, no probe, store still written
        run_pkt(1, 'hE2, 1, 64'h5A5A, 1, 1, 0, 'h320, 2, 0, 0, "R4 pred false");
        run_pkt(1, 'hE7, 0, 64'h81, 0, 0, 0, 0, 0, 0, 0, "R4 lone byte store");
        // R6: load in another slot reads old bytes first
        run_pkt(1, 'hF0, 2, 64'hCAFE_F00D, 1, 0, 1, 'hF0, 2, 0, 0, "R6 load first");
        run_pkt(0, 0, 0, 0, 1, 1, 1, 'hF0, 2, 0, 0, "R6 store landed");
        // R12: empty packet
        run_pkt(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 empty");
        run_pkt(0, 0, 0, 0, 1, 0, 0, 'h20, 0, 0, 0, "R12 pred false only");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule